// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block steps through a multi-register load or store. It accepts one command at a time. A command holds a base address, a one-hot-per-register selection list, the base register's index and five control bits: pre-step, step-up, writeback, load and the S bit. The block then issues one memory transfer per cycle. Each transfer carries a word address and the register index that the register file must source or sink. The memory side can hold off any transfer with a ready input. When the last transfer has been accepted, the block pulses a completion strobe and presents the updated base value for writeback.

Registers always move lowest index first, at the lowest address, whichever of the four stepping modes is chosen. Along with each transfer the block raises side flags:

- User-bank access is forced.
- The program counter is being stored together with the status bits.
- The status bits are to be restored from a loaded program counter.
- The register file should supply the already-updated base instead of the original base.

Top module: `blk_xfer_seq`

## Requirements
- R1: Bit i of `reg_list` selects register i. The selected registers are issued on `xfer_reg` in strictly ascending index order, one per accepted transfer. A transfer is accepted in a cycle where `xfer_valid` and `mem_ready` are both 1.
- R2: Addresses rise by 4 per transfer. With n selected registers, the first address depends on (`pre_step`, `step_up`) as follows: (0,1) gives base; (1,1) gives base+4; (0,0) gives base−4n+4; (1,0) gives base−4n. All arithmetic is modulo 2^32.
- R3: While `xfer_valid` is 1 and `mem_ready` is 0, the address and register index stay unchanged in the next cycle.
- R4: `done` is 1 for exactly one cycle, in the cycle after the last accepted transfer. `busy` is 1 from the cycle after `start` is accepted through the `done` cycle. A `start` while `busy` is 1 is ignored.
- R5: In the `done` cycle, `wb_value` is base+4n when `step_up`=1 and base−4n otherwise. `wb_valid` is 1 only when `write_back`=1 and `base_idx` is not 15.
- R6: An empty list produces no transfers. `done` is 1 in the cycle after `start`, and `wb_value` equals the base.
- R7: `xfer_base_new` is 1 on the transfer of register `base_idx` only for a store with `write_back`=1 where `base_idx` is not the lowest selected register. In every other case it is 0.
- R8: `xfer_pc_status` is 1 exactly on a store transfer of register 15.
- R9: `xfer_user_bank` is 1 on every transfer when `s_flag`=1 and either the command is a store or register 15 is not selected.
- R10: `xfer_status_load` is 1 exactly on the register-15 transfer of a load with `s_flag`=1.
- R11: After reset, `busy`, `xfer_valid`, `done` and `wb_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken when idle |
| base | input | DW | Base address value |
| base_idx | input | IW | Index of the base register |
| reg_list | input | NREG | Register selection list |
| pre_step | input | 1 | 1: step before each access |
| step_up | input | 1 | 1: ascending base, 0: descending |
| write_back | input | 1 | Request base update |
| is_load | input | 1 | 1: load, 0: store |
| s_flag | input | 1 | User-bank / status-restore control |
| mem_ready | input | 1 | Memory accepts the current transfer |
| busy | output | 1 | Command in progress |
| xfer_valid | output | 1 | Transfer presented |
| xfer_addr | output | DW | Word address of the transfer |
| xfer_reg | output | IW | Register index of the transfer |
| xfer_load | output | 1 | Transfer is a load |
| xfer_user_bank | output | 1 | Use user-mode register bank |
| xfer_pc_status | output | 1 | Store PC with status bits |
| xfer_status_load | output | 1 | Restore status from loaded PC |
| xfer_base_new | output | 1 | Supply updated base for this store |
| done | output | 1 | Completion pulse |
| wb_valid | output | 1 | Writeback of base required |
| wb_value | output | DW | Updated base value |

## Verification
The bench builds the block with its defaults: sixteen registers, 32-bit addresses and a 4-byte step. At these values register 15 exists, so the status-store, status-load and writeback-suppression rules can be reached. A full sixteen-register list gives long runs, so the pseudo-random ready stalls land in the middle of commands. The 32-bit width lets a descending command starting just above zero wrap through the top of the address space.

// File: rtl/blkx_pkg.sv
`timescale 1ns/1ps
package blkx_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_XFER = 2'd1,
    SQ_FIN  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/blkx_isolate.sv
`timescale 1ns/1ps
// Keeps only the least significant set bit of a vector.
module blkx_isolate #(
  parameter int N = 16
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] first_hot
);
  assign first_hot = vec & (~vec + N'(1));
endmodule

// File: rtl/blkx_enc.sv
`timescale 1ns/1ps
// One-hot to binary index encoder.
module blkx_enc #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  onehot,
  output logic [IW-1:0] idx
);
  for (genvar b = 0; b < IW; b++) begin : g_bit
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (((i >> b) % 2) == 1) acc = acc | onehot[i];
      end
    end
    assign idx[b] = acc;
  end
endmodule

// File: rtl/blkx_popcnt.sv
`timescale 1ns/1ps
module blkx_popcnt #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CW'(vec[i]);
  end
endmodule

// File: rtl/blkx_span.sv
`timescale 1ns/1ps
// First transfer address and final base value for a command.
module blkx_span #(
  parameter int DW   = 32,
  parameter int CW   = 5,
  parameter int STEP = 4
) (
  input  logic [DW-1:0] base,
  input  logic [CW-1:0] cnt,
  input  logic          pre_step,
  input  logic          step_up,
  output logic [DW-1:0] first_addr,
  output logic [DW-1:0] final_base
);
  logic [DW-1:0] span;
  logic [DW-1:0] step_w;

  assign span   = DW'(cnt) * DW'(STEP);
  assign step_w = DW'(STEP);

  always_comb begin
    if (step_up) begin
      final_base = base + span;
      first_addr = pre_step ? base + step_w : base;
    end else begin
      final_base = base - span;
      first_addr = pre_step ? base - span : base - span + step_w;
    end
  end
endmodule

// File: rtl/blk_xfer_seq.sv
`timescale 1ns/1ps
module blk_xfer_seq #(
  parameter  int NREG = 16,
  parameter  int DW   = 32,
  parameter  int STEP = 4,
  localparam int IW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   base,
  input  logic [IW-1:0]   base_idx,
  input  logic [NREG-1:0] reg_list,
  input  logic            pre_step,
  input  logic            step_up,
  input  logic            write_back,
  input  logic            is_load,
  input  logic            s_flag,
  input  logic            mem_ready,
  output logic            busy,
  output logic            xfer_valid,
  output logic [DW-1:0]   xfer_addr,
  output logic [IW-1:0]   xfer_reg,
  output logic            xfer_load,
  output logic            xfer_user_bank,
  output logic            xfer_pc_status,
  output logic            xfer_status_load,
  output logic            xfer_base_new,
  output logic            done,
  output logic            wb_valid,
  output logic [DW-1:0]   wb_value
);
  import blkx_pkg::*;

  localparam int CW = $clog2(NREG + 1);
  localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // command decode
  logic [NREG-1:0] list_first;
  logic [CW-1:0]   list_cnt;
  logic [DW-1:0]   first_addr, final_base;

  blkx_isolate #(.N(NREG)) u_list_first (.vec(reg_list), .first_hot(list_first));
  blkx_popcnt  #(.N(NREG), .CW(CW)) u_cnt (.vec(reg_list), .cnt(list_cnt));
  blkx_span    #(.DW(DW), .CW(CW), .STEP(STEP)) u_span (
    .base(base), .cnt(list_cnt), .pre_step(pre_step), .step_up(step_up),
    .first_addr(first_addr), .final_base(final_base)
  );

  // state
  sq_state_e       state_q, state_d;
  logic [NREG-1:0] mask_q, mask_d;
  logic [DW-1:0]   addr_q, addr_d;
  logic [CW-1:0]   remain_q, remain_d;
  logic [DW-1:0]   wb_q;
  logic            load_q, user_q, stld_q, alt_q, wbv_q;
  logic [IW-1:0]   bidx_q;

  logic [NREG-1:0] cur_hot;
  logic [IW-1:0]   cur_idx;

  blkx_isolate #(.N(NREG)) u_cur_first (.vec(mask_q), .first_hot(cur_hot));
  blkx_enc     #(.N(NREG), .IW(IW)) u_cur_enc (.onehot(cur_hot), .idx(cur_idx));

  logic cmd_en, step_en, last_step;
  logic cmd_user, cmd_stld, cmd_alt, cmd_wbv;

  assign cmd_en    = (state_q == SQ_IDLE) && start;
  assign step_en   = (state_q == SQ_XFER) && mem_ready;
  assign last_step = (remain_q == CW'(1));

  assign cmd_user = s_flag && (!is_load || !reg_list[PC_IDX]);
  assign cmd_stld = s_flag && is_load && reg_list[PC_IDX];
  assign cmd_alt  = !is_load && write_back && reg_list[base_idx] && !list_first[base_idx];
  assign cmd_wbv  = write_back && (base_idx != PC_IDX);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (start) state_d = (list_cnt == '0) ? SQ_FIN : SQ_XFER;
      SQ_XFER: if (mem_ready && last_step) state_d = SQ_FIN;
      SQ_FIN:  state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    mask_d   = mask_q;
    addr_d   = addr_q;
    remain_d = remain_q;
    if (cmd_en) begin
      mask_d   = reg_list;
      addr_d   = first_addr;
      remain_d = list_cnt;
    end else if (step_en) begin
      mask_d   = mask_q & ~cur_hot;
      addr_d   = addr_q + DW'(STEP);
      remain_d = remain_q - CW'(1);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= SQ_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q   <= '0;
      addr_q   <= '0;
      remain_q <= '0;
    end else if (cmd_en || step_en) begin
      mask_q   <= mask_d;
      addr_q   <= addr_d;
      remain_q <= remain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wb_q   <= '0;
      load_q <= 1'b0;
      user_q <= 1'b0;
      stld_q <= 1'b0;
      alt_q  <= 1'b0;
      wbv_q  <= 1'b0;
      bidx_q <= '0;
    end else if (cmd_en) begin
      wb_q   <= final_base;
      load_q <= is_load;
      user_q <= cmd_user;
      stld_q <= cmd_stld;
      alt_q  <= cmd_alt;
      wbv_q  <= cmd_wbv;
      bidx_q <= base_idx;
    end
  end

  // outputs
  logic cur_is_pc;
  assign cur_is_pc = (cur_idx == PC_IDX);

  assign busy             = (state_q != SQ_IDLE);
  assign xfer_valid       = (state_q == SQ_XFER);
  assign xfer_addr        = addr_q;
  assign xfer_reg         = cur_idx;
  assign xfer_load        = xfer_valid && load_q;
  assign xfer_user_bank   = xfer_valid && user_q;
  assign xfer_pc_status   = xfer_valid && !load_q && cur_is_pc;
  assign xfer_status_load = xfer_valid && stld_q && cur_is_pc;
  assign xfer_base_new    = xfer_valid && alt_q && (cur_idx == bidx_q);
  assign done             = (state_q == SQ_FIN);
  assign wb_valid         = done && wbv_q;
  assign wb_value         = wb_q;
endmodule

// File: rtl/blkx_chk.sv
`timescale 1ns/1ps
module blkx_chk #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int STEP = 4,
  parameter int IW   = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_ready,
  input logic          busy,
  input logic          xfer_valid,
  input logic [DW-1:0] xfer_addr,
  input logic [IW-1:0] xfer_reg,
  input logic          xfer_load,
  input logic          xfer_pc_status,
  input logic          done,
  input logic          wb_valid
);
  p_hold_on_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !mem_ready) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_reg)));

  p_addr_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && mem_ready) |=> (!xfer_valid || xfer_addr == $past(xfer_addr) + DW'(STEP)));

  p_reg_ascends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && mem_ready) |=> (!xfer_valid || xfer_reg > $past(xfer_reg)));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !xfer_valid));

  p_wb_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);

  p_pc_store_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pc_status |-> (xfer_valid && !xfer_load && xfer_reg == IW'(NREG - 1)));
endmodule

bind blk_xfer_seq blkx_chk #(.NREG(NREG), .DW(DW), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .busy(busy),
  .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_reg(xfer_reg),
  .xfer_load(xfer_load), .xfer_pc_status(xfer_pc_status),
  .done(done), .wb_valid(wb_valid)
);

// File: tb/tb_blk_xfer_seq.sv
`timescale 1ns/1ps
module tb_blk_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] base;
  logic [3:0]  base_idx;
  logic [15:0] reg_list;
  logic        pre_step, step_up, write_back, is_load, s_flag, mem_ready;
  logic        busy, xfer_valid, xfer_load, xfer_user_bank, xfer_pc_status;
  logic        xfer_status_load, xfer_base_new, done, wb_valid;
  logic [31:0] xfer_addr, wb_value;
  logic [3:0]  xfer_reg;

  always #5 clk = ~clk;

  blk_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .base_idx(base_idx),
    .reg_list(reg_list), .pre_step(pre_step), .step_up(step_up),
    .write_back(write_back), .is_load(is_load), .s_flag(s_flag),
    .mem_ready(mem_ready), .busy(busy), .xfer_valid(xfer_valid),
    .xfer_addr(xfer_addr), .xfer_reg(xfer_reg), .xfer_load(xfer_load),
    .xfer_user_bank(xfer_user_bank), .xfer_pc_status(xfer_pc_status),
    .xfer_status_load(xfer_status_load), .xfer_base_new(xfer_base_new),
    .done(done), .wb_valid(wb_valid), .wb_value(wb_value)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  rg;
    logic        ld, user, pcs, stl, bnew;
  } xfer_t;

  typedef struct packed {
    logic        v;
    logic [31:0] val;
  } wb_t;

  xfer_t exp_q[$];
  wb_t   wb_q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    rand_ready = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ready driver: changes just after each rising edge
  initial begin
    mem_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = rand_ready ? (lfsr[1] | lfsr[4]) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit          pend_done = 1'b0;
    bit          was_stall = 1'b0;
    logic [31:0] st_addr = '0;
    logic [3:0]  st_reg = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pend_done) begin
          check(done == 1'b1, "R4 done after last transfer", {63'd0, done}, 64'd1);
          pend_done = 1'b0;
        end
        if (was_stall) begin
          check(xfer_valid && xfer_addr == st_addr && xfer_reg == st_reg,
                "R3 hold during stall", {27'd0, xfer_valid, xfer_reg, xfer_addr},
                {27'd0, 1'b1, st_reg, st_addr});
        end
        was_stall = xfer_valid && !mem_ready;
        st_addr   = xfer_addr;
        st_reg    = xfer_reg;
        if (xfer_valid && mem_ready) begin
          xfer_t act;
          act = '{xfer_addr, xfer_reg, xfer_load, xfer_user_bank, xfer_pc_status,
                  xfer_status_load, xfer_base_new};
          if (exp_q.size() == 0) begin
            check(1'b0, "R1 unexpected transfer", 64'(act), 64'd0);
          end else begin
            xfer_t e;
            e = exp_q.pop_front();
            check(act == e, "R1 R2 R7 R8 R9 R10 transfer", 64'(act), 64'(e));
            if (exp_q.size() == 0) pend_done = 1'b1;
          end
        end
        if (done) begin
          if (wb_q.size() == 0) begin
            check(1'b0, "R4 unexpected done", 64'd1, 64'd0);
          end else begin
            wb_t w, a;
            w = wb_q.pop_front();
            a = '{wb_valid, wb_value};
            if (!w.v) a.val = w.val;
            check(a == w, "R5 writeback", 64'(a), 64'(w));
          end
        end
      end
    end
  end

  task automatic run_cmd(input logic [31:0] b, input logic [15:0] lst, input logic [3:0] bi,
                         input logic p, input logic u, input logic w, input logic l,
                         input logic s, input bit poke);
    int          n = 0;
    int          lowest = -1;
    int          k = 0;
    logic [31:0] first;
    for (int i = 0; i < 16; i++) if (lst[i]) begin
      n++;
      if (lowest < 0) lowest = i;
    end
    if (u) first = b + (p ? 32'd4 : 32'd0);
    else   first = b - 32'(4 * n) + (p ? 32'd0 : 32'd4);
    for (int i = 0; i < 16; i++) if (lst[i]) begin
      xfer_t e;
      e.addr = first + 32'(4 * k);
      e.rg   = 4'(i);
      e.ld   = l;
      e.user = s && (!l || !lst[15]);
      e.pcs  = !l && (i == 15);
      e.stl  = s && l && lst[15] && (i == 15);
      e.bnew = !l && w && lst[bi] && (lowest != int'(bi)) && (i == int'(bi));
      exp_q.push_back(e);
      k++;
    end
    wb_q.push_back('{w && (bi != 4'd15), u ? b + 32'(4 * n) : b - 32'(4 * n)});
    @(negedge clk);
    base = b; reg_list = lst; base_idx = bi;
    pre_step = p; step_up = u; write_back = w; is_load = l; s_flag = s;
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    if (poke) begin
      // R4: a second command while busy must be ignored
      reg_list = 16'hFFFF; base = 32'hDEAD_0000; start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
    end
    if (n == 0) begin
      @(negedge clk);
      check(done && !xfer_valid, "R6 empty list done next cycle",
            {62'd0, done, xfer_valid}, 64'd2);
    end else begin
      forever begin
        @(negedge clk);
        if (done) break;
      end
    end
    @(negedge clk);
    check(!busy, "R4 idle after done", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; base = '0; base_idx = '0; reg_list = '0;
    pre_step = 1'b0; step_up = 1'b0; write_back = 1'b0; is_load = 1'b0; s_flag = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !xfer_valid && !done && !wb_valid, "R11 reset state",
          {60'd0, busy, xfer_valid, done, wb_valid}, 64'd0);

    // increment-after store, base R13 not in list
    run_cmd(32'h0000_1000, 16'h00F1, 4'd13, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    // increment-before load with S and R15: status restore, normal bank
    run_cmd(32'h0000_2000, 16'h8003, 4'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    // decrement-after store with S: user bank, PC with status
    run_cmd(32'h0000_3000, 16'h8410, 4'd13, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    // decrement-before store, base R8 in list but not lowest (R7)
    run_cmd(32'h0000_4000, 16'h0106, 4'd8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // base R8 lowest in list: original base (R7)
    run_cmd(32'h0000_4000, 16'h0300, 4'd8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // empty list (R6)
    run_cmd(32'h0000_5000, 16'h0000, 4'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    // load with S, no R15: user bank (R9)
    run_cmd(32'h0000_6000, 16'h0C00, 4'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);

    rand_ready = 1'b1;
    // full list, base R15: writeback suppressed (R5), stalls (R3)
    run_cmd(32'h0001_0000, 16'hFFFF, 4'd15, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    // decrement wrap through zero, with start poked while busy (R4)
    run_cmd(32'h0000_0008, 16'h0007, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    // full list store decrement-after with S
    run_cmd(32'h0002_0000, 16'hFFFF, 4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    rand_ready = 1'b0;

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0 && wb_q.size() == 0, "R1 scoreboard drained",
          64'(exp_q.size() + wb_q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule